// File: doc/BRIEF.md
# Monitor channel handshake controller

This block carries two-byte register messages over the Monitor byte of a time-slotted serial frame. Each message is an address byte followed by a data byte. The E bit of the signalling byte flags a new byte from the sender, and the A bit carries the receiver's acknowledgement. The slot interface gives one strobe per 8 kHz frame, together with the received Monitor byte, E bit and A bit. At that strobe the block samples those fields and computes the Monitor byte, E bit and A bit that it sends in the next frame.

The transmit half takes a request (address and data) from the user side. It waits until the far end's A bit has read released on two frames in a row. It then sends the address with E low and holds it until the far end answers with A low. Next it releases E until A is released again, and sends the data byte the same way. If no answer arrives within a set number of frames, it abandons the message and reports an error. The receive half works on its own. It catches each byte where E falls, answers with A low from the next frame on, and pairs the bytes into address and data for the user side.

Top module: `mon_handshake`

## Requirements
- R1: After reset, tx_e and tx_a are 1 (released), tx_mon is 8'hFF, and msg_busy, msg_done, msg_err and got_valid are 0.
- R2: A pending message starts only on a strobe where rx_a is 1 and rx_a was also 1 on the previous strobe. From the next frame, tx_mon carries the address byte with tx_e = 0.
- R3: While a byte is sent, tx_mon and tx_e = 0 hold until a strobe samples rx_a = 0. From the next frame, tx_e is 1.
- R4: After the address is acknowledged, tx_e stays 1 for as long as rx_a reads 0. On the first strobe with rx_a = 1, the data byte goes out with tx_e = 0 in the next frame.
- R5: When the data byte is acknowledged, tx_e returns to 1, tx_mon to 8'hFF, and msg_done pulses for one clock. msg_busy drops, and a new message again needs two fresh strobes with rx_a = 1.
- R6: If TMO_FRAMES (default 32) strobes pass in a waiting step without the expected rx_a level, the message is dropped. tx_e becomes 1, tx_mon 8'hFF, msg_err pulses and msg_busy drops.
- R7: A byte is captured on a strobe where rx_e is 0 and was 1 on the previous strobe. tx_a is 0 from the next frame while rx_e stays 0, and returns to 1 the frame after rx_e reads 1.
- R8: The first captured byte of a message is the address and the second is the data. After the second, got_addr and got_data carry both, and got_valid pulses for one clock.
- R9: If rx_e reads 1 on RESYNC_FRAMES (default 4) consecutive strobes, a lone captured address byte is discarded, and the next captured byte is taken as an address.
- R10: Between strobes, tx_mon, tx_e and tx_a do not change, whatever the rx inputs do.
- R11: A msg_go pulse while msg_busy is 1 is ignored; the message in progress keeps its address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_stb | input | 1 | One-clock pulse per frame; rx fields valid |
| rx_mon | input | 8 | Received Monitor byte |
| rx_e | input | 1 | Received E bit (0 = new byte) |
| rx_a | input | 1 | Received A bit (0 = acknowledge) |
| tx_mon | output | 8 | Monitor byte to send, 8'hFF when released |
| tx_e | output | 1 | E bit to send |
| tx_a | output | 1 | A bit to send |
| msg_go | input | 1 | Request pulse for a new message |
| msg_addr | input | 8 | Address byte of the request |
| msg_data | input | 8 | Data byte of the request |
| msg_busy | output | 1 | Request accepted and not yet finished |
| msg_done | output | 1 | One-clock pulse: message acknowledged |
| msg_err | output | 1 | One-clock pulse: message aborted on timeout |
| got_valid | output | 1 | One-clock pulse: a received pair is ready |
| got_addr | output | 8 | Received address byte |
| got_data | output | 8 | Received data byte |

## Verification
A frame-by-frame table runs a full outgoing message and a full incoming message at the same time. The incoming address and data bytes are equal, so capture must come from the falling E edge and not from a change in the byte. The table also keeps a stale A low during the gap, which shows whether the sender waits for A to be released. Directed runs then cover three more cases. A broken run of released A bits checks the two-frame start rule. A silent far end checks the abort after TMO_FRAMES. A lone address byte followed by a long released E checks the resynchronisation of the receive pairing.

// File: rtl/mon_hs_pkg.sv
package mon_hs_pkg;

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_BYTE0 = 2'd1,
    TX_GAP   = 2'd2,
    TX_BYTE1 = 2'd3
  } tx_state_e;

  localparam logic [7:0] MON_RELEASED = 8'hFF;

  // saturating frame counter step
  function automatic int unsigned sat_inc(int unsigned v, int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

  // true when this strobe completes the required run of released A bits
  function automatic logic may_start(int unsigned run, logic a, int unsigned need);
    return a && ((run + 1) >= need);
  endfunction

endpackage

// File: rtl/mon_tx_ctl.sv
module mon_tx_ctl
  import mon_hs_pkg::*;
#(
  parameter int unsigned W           = 8,
  parameter int unsigned IDLE_FRAMES = 2,
  parameter int unsigned TMO_FRAMES  = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stb,
  input  logic         rx_a,
  input  logic         go,
  input  logic [W-1:0] addr,
  input  logic [W-1:0] data,
  output logic [W-1:0] tx_mon,
  output logic         tx_e,
  output logic         busy,
  output logic         done,
  output logic         err,
  output logic         ev_start,
  output logic         ev_ack,
  output logic         ev_abort
);
  localparam int CW = $clog2(TMO_FRAMES + 1);
  localparam int IW = $clog2(IDLE_FRAMES + 1);

  tx_state_e      state;
  logic           pend;
  logic [W-1:0]   addr_q, data_q;
  logic [IW-1:0]  idle_run;
  logic [CW-1:0]  wait_cnt;
  logic           got;

  assign busy = pend || (state != TX_IDLE);

  always_comb begin
    got      = (state == TX_GAP) ? rx_a : !rx_a;
    ev_start = stb && (state == TX_IDLE) && pend &&
               may_start(32'(idle_run), rx_a, IDLE_FRAMES);
    ev_ack   = stb && ((state == TX_BYTE0) || (state == TX_BYTE1)) && !rx_a;
    ev_abort = stb && (state != TX_IDLE) && !got &&
               (32'(wait_cnt) == TMO_FRAMES - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= TX_IDLE;
      pend     <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
      idle_run <= '0;
      wait_cnt <= '0;
      tx_mon   <= MON_RELEASED;
      tx_e     <= 1'b1;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (go && !busy) begin
        pend   <= 1'b1;
        addr_q <= addr;
        data_q <= data;
      end
      if (stb) begin
        if (state == TX_IDLE) begin
          if (ev_start) begin
            state    <= TX_BYTE0;
            tx_mon   <= addr_q;
            tx_e     <= 1'b0;
            wait_cnt <= '0;
            idle_run <= '0;
          end else begin
            idle_run <= rx_a ? IW'(sat_inc(32'(idle_run), IDLE_FRAMES)) : '0;
          end
        end else if (ev_abort) begin
          state    <= TX_IDLE;
          tx_e     <= 1'b1;
          tx_mon   <= MON_RELEASED;
          pend     <= 1'b0;
          err      <= 1'b1;
          idle_run <= '0;
          wait_cnt <= '0;
        end else if (got) begin
          wait_cnt <= '0;
          case (state)
            TX_BYTE0: begin
              state <= TX_GAP;
              tx_e  <= 1'b1;
            end
            TX_GAP: begin
              state  <= TX_BYTE1;
              tx_mon <= data_q;
              tx_e   <= 1'b0;
            end
            default: begin
              state    <= TX_IDLE;
              tx_e     <= 1'b1;
              tx_mon   <= MON_RELEASED;
              pend     <= 1'b0;
              done     <= 1'b1;
              idle_run <= '0;
            end
          endcase
        end else begin
          wait_cnt <= CW'(sat_inc(32'(wait_cnt), TMO_FRAMES));
        end
      end
    end
  end
endmodule

// File: rtl/mon_rx_ctl.sv
module mon_rx_ctl
  import mon_hs_pkg::*;
#(
  parameter int unsigned W             = 8,
  parameter int unsigned RESYNC_FRAMES = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stb,
  input  logic [W-1:0] rx_mon,
  input  logic         rx_e,
  output logic         tx_a,
  output logic         got_valid,
  output logic [W-1:0] got_addr,
  output logic [W-1:0] got_data,
  output logic         ev_capture
);
  localparam int HW = $clog2(RESYNC_FRAMES + 1);

  logic          prev_e;
  logic          second;
  logic [W-1:0]  addr_q;
  logic [HW-1:0] hi_run;

  assign ev_capture = stb && !rx_e && prev_e;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_e    <= 1'b1;
      second    <= 1'b0;
      addr_q    <= '0;
      hi_run    <= '0;
      tx_a      <= 1'b1;
      got_valid <= 1'b0;
      got_addr  <= '0;
      got_data  <= '0;
    end else begin
      got_valid <= 1'b0;
      if (stb) begin
        prev_e <= rx_e;
        if (rx_e) begin
          tx_a   <= 1'b1;
          hi_run <= HW'(sat_inc(32'(hi_run), RESYNC_FRAMES));
          if ((32'(hi_run) + 1) >= RESYNC_FRAMES) second <= 1'b0;
        end else begin
          hi_run <= '0;
          if (ev_capture) begin
            tx_a <= 1'b0;
            if (!second) begin
              addr_q <= rx_mon;
              second <= 1'b1;
            end else begin
              got_addr  <= addr_q;
              got_data  <= rx_mon;
              got_valid <= 1'b1;
              second    <= 1'b0;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/mon_handshake.sv
module mon_handshake
  import mon_hs_pkg::*;
#(
  parameter int unsigned IDLE_FRAMES   = 2,
  parameter int unsigned TMO_FRAMES    = 32,
  parameter int unsigned RESYNC_FRAMES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_stb,
  input  logic [7:0] rx_mon,
  input  logic       rx_e,
  input  logic       rx_a,
  output logic [7:0] tx_mon,
  output logic       tx_e,
  output logic       tx_a,
  input  logic       msg_go,
  input  logic [7:0] msg_addr,
  input  logic [7:0] msg_data,
  output logic       msg_busy,
  output logic       msg_done,
  output logic       msg_err,
  output logic       got_valid,
  output logic [7:0] got_addr,
  output logic [7:0] got_data
);
  localparam int unsigned W = 8;

  // internal events, named for the checker
  logic ev_start, ev_ack, ev_abort, ev_capture;

  mon_tx_ctl #(
    .W(W), .IDLE_FRAMES(IDLE_FRAMES), .TMO_FRAMES(TMO_FRAMES)
  ) u_tx (
    .clk(clk), .rst_n(rst_n), .stb(frame_stb), .rx_a(rx_a),
    .go(msg_go), .addr(msg_addr), .data(msg_data),
    .tx_mon(tx_mon), .tx_e(tx_e), .busy(msg_busy),
    .done(msg_done), .err(msg_err),
    .ev_start(ev_start), .ev_ack(ev_ack), .ev_abort(ev_abort)
  );

  mon_rx_ctl #(
    .W(W), .RESYNC_FRAMES(RESYNC_FRAMES)
  ) u_rx (
    .clk(clk), .rst_n(rst_n), .stb(frame_stb),
    .rx_mon(rx_mon), .rx_e(rx_e), .tx_a(tx_a),
    .got_valid(got_valid), .got_addr(got_addr), .got_data(got_data),
    .ev_capture(ev_capture)
  );
endmodule

// File: rtl/mon_handshake_chk.sv
module mon_handshake_chk #(
  parameter int unsigned IDLE_FRAMES = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_stb,
  input logic       rx_a,
  input logic [7:0] tx_mon,
  input logic       tx_e,
  input logic       tx_a,
  input logic       msg_busy,
  input logic       msg_done,
  input logic       msg_err,
  input logic       got_valid,
  input logic       ev_start,
  input logic       ev_ack,
  input logic       ev_abort,
  input logic       ev_capture
);
  localparam int AW = $clog2(IDLE_FRAMES + 1);
  logic [AW-1:0] a_run;

  // own count of consecutive strobes with rx_a released, before this one
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) a_run <= '0;
    else if (frame_stb) begin
      if (!rx_a) a_run <= '0;
      else if (32'(a_run) < IDLE_FRAMES) a_run <= a_run + 1'b1;
    end
  end

  p_release_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_busy |-> (tx_e && tx_mon == 8'hFF));
  p_start_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |-> (rx_a && (32'(a_run) + 1 >= IDLE_FRAMES)));
  p_start_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> !tx_e);
  p_hold_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_e && !ev_ack && !ev_abort) |=> (!tx_e && $stable(tx_mon)));
  p_ack_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ack |=> tx_e);
  p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(msg_done && msg_err));
  p_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> (msg_err && tx_e && !msg_busy));
  p_capture_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_capture |=> !tx_a);
  p_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
    got_valid |-> $past(ev_capture));
  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |=> ($stable(tx_e) && $stable(tx_a) && $stable(tx_mon)));
endmodule

bind mon_handshake mon_handshake_chk #(.IDLE_FRAMES(IDLE_FRAMES)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .rx_a(rx_a),
  .tx_mon(tx_mon), .tx_e(tx_e), .tx_a(tx_a), .msg_busy(msg_busy),
  .msg_done(msg_done), .msg_err(msg_err), .got_valid(got_valid),
  .ev_start(ev_start), .ev_ack(ev_ack), .ev_abort(ev_abort),
  .ev_capture(ev_capture)
);

// File: tb/test_mon_handshake.sv
module test_mon_handshake;
  localparam int TMO = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_stb = 1'b0;
  logic [7:0] rx_mon = 8'hFF;
  logic rx_e = 1'b1, rx_a = 1'b1;
  logic [7:0] tx_mon;
  logic tx_e, tx_a;
  logic msg_go = 1'b0;
  logic [7:0] msg_addr = '0, msg_data = '0;
  logic msg_busy, msg_done, msg_err, got_valid;
  logic [7:0] got_addr, got_data;

  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  mon_handshake i_mon_handshake (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb),
    .rx_mon(rx_mon), .rx_e(rx_e), .rx_a(rx_a),
    .tx_mon(tx_mon), .tx_e(tx_e), .tx_a(tx_a),
    .msg_go(msg_go), .msg_addr(msg_addr), .msg_data(msg_data),
    .msg_busy(msg_busy), .msg_done(msg_done), .msg_err(msg_err),
    .got_valid(got_valid), .got_addr(got_addr), .got_data(got_data)
  );

  // {rx_mon, rx_e, rx_a, exp tx_mon, exp tx_e, exp tx_a, exp done, exp got_valid}
  localparam logic [21:0] VEC [9] = '{
    {8'hFF, 1'b1, 1'b1, 8'hFF, 1'b1, 1'b1, 1'b0, 1'b0},
    {8'h81, 1'b0, 1'b1, 8'h3C, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'h81, 1'b0, 1'b1, 8'h3C, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'hFF, 1'b1, 1'b0, 8'h3C, 1'b1, 1'b1, 1'b0, 1'b0},
    {8'hFF, 1'b1, 1'b0, 8'h3C, 1'b1, 1'b1, 1'b0, 1'b0},
    {8'h81, 1'b0, 1'b1, 8'h5A, 1'b0, 1'b0, 1'b0, 1'b1},
    {8'h81, 1'b0, 1'b1, 8'h5A, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'hFF, 1'b1, 1'b0, 8'hFF, 1'b1, 1'b1, 1'b1, 1'b0},
    {8'hFF, 1'b1, 1'b0, 8'hFF, 1'b1, 1'b1, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one frame: present rx fields with a one-clock strobe, return just after the edge
  task automatic frame(input logic [7:0] m, input logic e, input logic a);
    @(negedge clk);
    rx_mon = m; rx_e = e; rx_a = a; frame_stb = 1'b1;
    @(posedge clk);
    #1 frame_stb = 1'b0;
  endtask

  task automatic request(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    msg_go = 1'b1; msg_addr = a; msg_data = d;
    @(negedge clk);
    msg_go = 1'b0;
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset tx_e", 32'(tx_e), 1);
    chk("R1 reset tx_a", 32'(tx_a), 1);
    chk("R1 reset tx_mon", 32'(tx_mon), 32'hFF);
    chk("R1 reset busy/done/err/valid", {28'd0, msg_busy, msg_done, msg_err, got_valid}, 0);
    @(negedge clk) rst_n = 1'b1;

    // table: outgoing 3C/5A and incoming 81/81 interleaved
    request(8'h3C, 8'h5A);
    for (int i = 0; i < 9; i++) begin
      logic [21:0] v;
      v = VEC[i];
      frame(v[21:14], v[13], v[12]);
      chk($sformatf("R2 R3 R4 R5 tx_mon frame %0d", i), 32'(tx_mon), 32'(v[11:4]));
      chk($sformatf("R3 R4 tx_e frame %0d", i), 32'(tx_e), 32'(v[3]));
      chk($sformatf("R7 tx_a frame %0d", i), 32'(tx_a), 32'(v[2]));
      chk($sformatf("R5 done frame %0d", i), 32'(msg_done), 32'(v[1]));
      chk($sformatf("R8 got_valid frame %0d", i), 32'(got_valid), 32'(v[0]));
    end
    chk("R8 pair address", 32'(got_addr), 32'h81);
    chk("R8 pair data", 32'(got_data), 32'h81);
    chk("R5 busy after done", 32'(msg_busy), 0);

    // R2 broken run, R11 second request ignored, R4 gap wait
    request(8'hAA, 8'hBB);
    request(8'h11, 8'h22);
    frame(8'hFF, 1'b1, 1'b1);
    chk("R2 one released frame not enough", 32'(tx_e), 1);
    frame(8'hFF, 1'b1, 1'b0);
    frame(8'hFF, 1'b1, 1'b1);
    chk("R2 run broken by A=0", 32'(tx_e), 1);
    frame(8'hFF, 1'b1, 1'b1);
    chk("R2 start after two released", 32'(tx_e), 0);
    chk("R11 address kept", 32'(tx_mon), 32'hAA);
    frame(8'hFF, 1'b1, 1'b0);
    chk("R3 E released after ack", 32'(tx_e), 1);
    frame(8'hFF, 1'b1, 1'b0);
    chk("R4 stays in gap while A low", 32'(tx_e), 1);
    frame(8'hFF, 1'b1, 1'b1);
    chk("R4 data byte sent", 32'(tx_e), 0);
    chk("R11 data kept", 32'(tx_mon), 32'hBB);
    frame(8'hFF, 1'b1, 1'b0);
    chk("R5 done pulse", 32'(msg_done), 1);
    chk("R5 released byte", 32'(tx_mon), 32'hFF);

    // R5 fresh run needed, then R6 timeout
    request(8'h44, 8'h55);
    frame(8'hFF, 1'b1, 1'b1);
    chk("R5 new message waits for fresh run", 32'(tx_e), 1);
    frame(8'hFF, 1'b1, 1'b1);
    chk("R6 started before silence", 32'(tx_e), 0);
    for (int k = 0; k < TMO - 1; k++) frame(8'hFF, 1'b1, 1'b1);
    chk("R6 still waiting one frame before limit", 32'(tx_e), 0);
    chk("R6 no error yet", 32'(msg_err), 0);
    frame(8'hFF, 1'b1, 1'b1);
    chk("R6 error pulse", 32'(msg_err), 1);
    chk("R6 E released", 32'(tx_e), 1);
    chk("R6 busy dropped", 32'(msg_busy), 0);

    // R9 resync of receive pairing, R7 A answer
    frame(8'h11, 1'b0, 1'b1);
    chk("R7 A low after capture", 32'(tx_a), 0);
    frame(8'hFF, 1'b1, 1'b1);
    chk("R7 A released after E high", 32'(tx_a), 1);
    for (int k = 0; k < 3; k++) frame(8'hFF, 1'b1, 1'b1);
    frame(8'h22, 1'b0, 1'b1);
    chk("R9 no pair from stale address", 32'(got_valid), 0);
    frame(8'hFF, 1'b1, 1'b1);
    frame(8'h33, 1'b0, 1'b1);
    chk("R9 pair valid", 32'(got_valid), 1);
    chk("R9 pair address", 32'(got_addr), 32'h22);
    chk("R9 pair data", 32'(got_data), 32'h33);
    frame(8'hFF, 1'b1, 1'b1);

    // R10 no change between strobes
    request(8'h77, 8'h66);
    frame(8'hFF, 1'b1, 1'b1);
    frame(8'hFF, 1'b1, 1'b1);
    chk("R10 setup start", 32'(tx_mon), 32'h77);
    @(negedge clk);
    rx_a = 1'b0; rx_e = 1'b0; rx_mon = 8'h12;
    repeat (5) @(negedge clk);
    chk("R10 tx_e held", 32'(tx_e), 0);
    chk("R10 tx_mon held", 32'(tx_mon), 32'h77);
    chk("R10 tx_a held", 32'(tx_a), 1);

    // R1 reset mid-message
    rst_n = 1'b0;
    #1;
    chk("R1 reset releases E", 32'(tx_e), 1);
    chk("R1 reset releases byte", 32'(tx_mon), 32'hFF);
    chk("R1 reset clears busy", 32'(msg_busy), 0);

    summary();
    $finish;
  end
endmodule